// File: doc/BRIEF.md
# EDID Native Timing Selector

This block takes the detailed-descriptor area of a display identification block as a byte stream (four descriptors of 18 bytes each, 72 bytes in all) and picks the display's native mode from it. Each descriptor that is a detailed timing is unpacked. The widest one is kept. Its offset and width fields are turned into absolute positions, so the block produces a complete timing record: pixel clock in kHz, and the display, sync-start, sync-end and total counts for both axes. The record also carries the sync polarity flags, the interlace flag and a digital-input flag.

A host or sequencer feeds the bytes as they are read from the monitor, one byte per cycle while `byte_valid_i` is high, and idle cycles may come between them. One cycle after the last byte of a block is accepted, `done_o` pulses and the record outputs take their new values. The outputs then hold until the next block completes. `mode_valid_o` reports whether the chosen mode exists and is at least 640 by 480.

Top module: `edid_native_select`

## Requirements
- R1: After reset, `done_o`, `mode_valid_o`, `digital_o`, every flag and every timing and clock output are 0.
- R2: Within a descriptor, byte 0 is the low byte and byte 1 the high byte of the raw pixel clock. Active width is {byte4[7:4], byte2} and horizontal blank is {byte4[3:0], byte3}. Active height is {byte7[7:4], byte5} and vertical blank is {byte7[3:0], byte6}. Horizontal sync offset is {byte11[7:6], byte8} and horizontal sync width is {byte11[5:4], byte9}. Vertical sync offset is {byte11[3:2], byte10[7:4]} and vertical sync width is {byte11[1:0], byte10[3:0]}.
- R3: On each axis, sync start = active + sync offset, sync end = sync start + sync width, and total = active + blank. No bits are lost, even with every field at its maximum.
- R4: `pclk_o` equals the raw clock value of the chosen descriptor times 10.
- R5: A descriptor whose raw clock is 0 is never chosen, whatever its other bytes contain.
- R6: Descriptors are visited in stream order. A descriptor replaces the current choice only if its active width is strictly larger, so on equal widths the earlier one wins. Height plays no part in the choice.
- R7: Byte 17 bits [4:3] hold the sync kind. Only when they equal 3 does byte17[1] drive `hsync_pos_o` and byte17[2] drive `vsync_pos_o`; for any other kind both flags are 0.
- R8: `interlace_o` is byte17[7] of the chosen descriptor.
- R9: `mode_valid_o` is 1 only if a mode was chosen with width at least 640 and height at least 480. An undersized choice is still reported on the timing outputs. With no mode chosen, all record outputs are 0.
- R10: `done_o` is high for exactly the one cycle after the 72nd byte is accepted. The record outputs change only in that cycle and hold otherwise.
- R11: `digital_o` takes the value of `digital_in_i` sampled together with the last byte of the block.
- R12: Every block is judged on its own; no choice carries over from an earlier block.
- R13: Bytes are taken only in cycles where `byte_valid_i` is high. Idle cycles inside a block do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid_i | input | 1 | A descriptor byte is present this cycle |
| byte_i | input | 8 | Descriptor byte |
| digital_in_i | input | 1 | Input-type bit from the display parameters |
| done_o | output | 1 | One-cycle pulse: new record available |
| mode_valid_o | output | 1 | Chosen mode exists and is at least 640x480 |
| pclk_o | output | 20 | Pixel clock in kHz |
| h_disp_o | output | 14 | Horizontal active pixels |
| h_sync_start_o | output | 14 | Horizontal sync start position |
| h_sync_end_o | output | 14 | Horizontal sync end position |
| h_total_o | output | 14 | Horizontal total |
| v_disp_o | output | 14 | Vertical active lines |
| v_sync_start_o | output | 14 | Vertical sync start line |
| v_sync_end_o | output | 14 | Vertical sync end line |
| v_total_o | output | 14 | Vertical total |
| hsync_pos_o | output | 1 | Positive horizontal sync |
| vsync_pos_o | output | 1 | Positive vertical sync |
| interlace_o | output | 1 | Interlaced mode |
| digital_o | output | 1 | Digital display input |

## Verification
The properties assume that every block arrives complete, 72 accepted bytes, before the next one starts, and that `byte_valid_i` is never unknown after reset. They do not depend on byte contents, because the order relations they check follow from unsigned sums whatever the fields hold. The stimulus drives only whole blocks through a single task, holds `byte_valid_i` low between blocks, and keeps `digital_in_i` steady during each block.

// File: rtl/edid_sel_pkg.sv
// Shared widths, codes and record types for the native timing selector.
// Assumes the 18-byte detailed descriptor layout with 12-bit size fields.
package edid_sel_pkg;
    localparam int DESC_BYTES = 18;          // bytes per descriptor
    localparam int KEEP_BYTES = 12;          // leading bytes that carry timing fields
    localparam int CLK_RAW_W  = 16;          // raw clock field width
    localparam int PCLK_W     = CLK_RAW_W + 4; // room for the x10 scaling
    localparam int TIME_W     = 14;          // 12-bit size plus two additions
    localparam logic [1:0] SEP_SYNC_KIND = 2'd3;

    // Raw fields unpacked from one descriptor
    typedef struct packed {
        logic [CLK_RAW_W-1:0] clk_raw;
        logic [11:0] h_act;
        logic [11:0] h_blk;
        logic [11:0] v_act;
        logic [11:0] v_blk;
        logic [9:0]  h_off;
        logic [9:0]  h_wid;
        logic [5:0]  v_off;
        logic [5:0]  v_wid;
        logic [1:0]  sync_kind;
        logic        pol_h;
        logic        pol_v;
        logic        intl;
    } dtd_fields_t;

    // Timing record in absolute positions
    typedef struct packed {
        logic [PCLK_W-1:0] pclk;
        logic [TIME_W-1:0] h_disp;
        logic [TIME_W-1:0] h_ss;
        logic [TIME_W-1:0] h_se;
        logic [TIME_W-1:0] h_tot;
        logic [TIME_W-1:0] v_disp;
        logic [TIME_W-1:0] v_ss;
        logic [TIME_W-1:0] v_se;
        logic [TIME_W-1:0] v_tot;
        logic              pos_h;
        logic              pos_v;
        logic              intl;
    } mode_rec_t;
endpackage

// File: rtl/edid_dtd_collect.sv
// Counts incoming bytes into descriptor slots, keeps the leading bytes that
// hold timing fields and unpacks them. The strobe and the fields are presented
// combinationally in the cycle the final byte of a descriptor is accepted.
// Assumes blocks arrive whole: NUM_DESC descriptors of DESC_BYTES bytes each.
module edid_dtd_collect
    import edid_sel_pkg::*;
#(
    parameter int NUM_DESC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_valid_i,
    input  logic [7:0]  byte_i,
    output dtd_fields_t fields_o,
    output logic        fields_stb_o,
    output logic        first_desc_o,
    output logic        last_desc_o
);
    localparam int BIDX_W  = $clog2(DESC_BYTES);
    localparam int DIDX_W  = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1;
    localparam logic [BIDX_W-1:0] BYTE_LAST = BIDX_W'(DESC_BYTES - 1);
    localparam logic [DIDX_W-1:0] DESC_LAST = DIDX_W'(NUM_DESC - 1);

    logic [BIDX_W-1:0] byte_idx_q;
    logic [DIDX_W-1:0] desc_idx_q;
    logic [7:0]        keep_q [KEEP_BYTES];
    logic              at_last_byte;
    logic [7:0]        tail;

    assign at_last_byte = (byte_idx_q == BYTE_LAST);

    // Track byte position inside a descriptor and descriptor position in the block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_idx_q <= '0;
            desc_idx_q <= '0;
        end else if (byte_valid_i) begin
            if (at_last_byte) begin
                byte_idx_q <= '0;
                desc_idx_q <= (desc_idx_q == DESC_LAST) ? '0 : desc_idx_q + 1'b1;
            end else begin
                byte_idx_q <= byte_idx_q + 1'b1;
            end
        end
    end

    // One holding register per kept byte position
    for (genvar g = 0; g < KEEP_BYTES; g++) begin : g_keep
        always_ff @(posedge clk) begin
            if (!rst_n)
                keep_q[g] <= '0;
            else if (byte_valid_i && byte_idx_q == BIDX_W'(g))
                keep_q[g] <= byte_i;
        end
    end

    assign tail = byte_i;

    // Unpack split and packed fields; the flag byte is the live final byte
    always_comb begin
        fields_o.clk_raw   = {keep_q[1], keep_q[0]};
        fields_o.h_act     = {keep_q[4][7:4], keep_q[2]};
        fields_o.h_blk     = {keep_q[4][3:0], keep_q[3]};
        fields_o.v_act     = {keep_q[7][7:4], keep_q[5]};
        fields_o.v_blk     = {keep_q[7][3:0], keep_q[6]};
        fields_o.h_off     = {keep_q[11][7:6], keep_q[8]};
        fields_o.h_wid     = {keep_q[11][5:4], keep_q[9]};
        fields_o.v_off     = {keep_q[11][3:2], keep_q[10][7:4]};
        fields_o.v_wid     = {keep_q[11][1:0], keep_q[10][3:0]};
        fields_o.sync_kind = tail[4:3];
        fields_o.pol_v     = tail[2];
        fields_o.pol_h     = tail[1];
        fields_o.intl      = tail[7];
    end

    assign fields_stb_o = byte_valid_i && at_last_byte;
    assign first_desc_o = (desc_idx_q == '0);
    assign last_desc_o  = (desc_idx_q == DESC_LAST);
endmodule

// File: rtl/edid_mode_calc.sv
// Converts unpacked descriptor fields into an absolute timing record:
// offsets and widths become positions, blank becomes total, the clock is
// scaled to kHz and polarity is kept only for separate-sync descriptors.
// Purely combinational; assumes field widths from edid_sel_pkg.
module edid_mode_calc
    import edid_sel_pkg::*;
(
    input  dtd_fields_t fields_i,
    output mode_rec_t   rec_o
);
    logic sep_sync;

    assign sep_sync = (fields_i.sync_kind == SEP_SYNC_KIND);

    // Position arithmetic and flag gating
    always_comb begin
        rec_o.pclk   = PCLK_W'(fields_i.clk_raw) * PCLK_W'(10);
        rec_o.h_disp = TIME_W'(fields_i.h_act);
        rec_o.h_ss   = TIME_W'(fields_i.h_act) + TIME_W'(fields_i.h_off);
        rec_o.h_se   = rec_o.h_ss + TIME_W'(fields_i.h_wid);
        rec_o.h_tot  = TIME_W'(fields_i.h_act) + TIME_W'(fields_i.h_blk);
        rec_o.v_disp = TIME_W'(fields_i.v_act);
        rec_o.v_ss   = TIME_W'(fields_i.v_act) + TIME_W'(fields_i.v_off);
        rec_o.v_se   = rec_o.v_ss + TIME_W'(fields_i.v_wid);
        rec_o.v_tot  = TIME_W'(fields_i.v_act) + TIME_W'(fields_i.v_blk);
        rec_o.pos_h  = sep_sync && fields_i.pol_h;
        rec_o.pos_v  = sep_sync && fields_i.pol_v;
        rec_o.intl   = fields_i.intl;
    end
endmodule

// File: rtl/edid_native_select.sv
// Top of the native timing selector. Keeps the strictly widest detailed
// timing of each block, latches the final record with a size check and a
// one-cycle done pulse after the last byte. Assumes whole blocks of NUM_DESC
// descriptors; digital_in_i is sampled with the final byte.
module edid_native_select
    import edid_sel_pkg::*;
#(
    parameter int NUM_DESC = 4,
    parameter int MIN_H    = 640,
    parameter int MIN_V    = 480
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_i,
    input  logic              digital_in_i,
    output logic              done_o,
    output logic              mode_valid_o,
    output logic [PCLK_W-1:0] pclk_o,
    output logic [TIME_W-1:0] h_disp_o,
    output logic [TIME_W-1:0] h_sync_start_o,
    output logic [TIME_W-1:0] h_sync_end_o,
    output logic [TIME_W-1:0] h_total_o,
    output logic [TIME_W-1:0] v_disp_o,
    output logic [TIME_W-1:0] v_sync_start_o,
    output logic [TIME_W-1:0] v_sync_end_o,
    output logic [TIME_W-1:0] v_total_o,
    output logic              hsync_pos_o,
    output logic              vsync_pos_o,
    output logic              interlace_o,
    output logic              digital_o
);
    dtd_fields_t fields;
    logic        fields_stb, first_desc, last_desc;
    mode_rec_t   cand, base, next_best, best_q, out_q;
    logic        take, valid_q, dig_q, done_q;

    edid_dtd_collect #(.NUM_DESC(NUM_DESC)) u_collect (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_valid_i (byte_valid_i),
        .byte_i       (byte_i),
        .fields_o     (fields),
        .fields_stb_o (fields_stb),
        .first_desc_o (first_desc),
        .last_desc_o  (last_desc)
    );

    edid_mode_calc u_calc (
        .fields_i (fields),
        .rec_o    (cand)
    );

    // Choose between the running best and the candidate of this descriptor
    always_comb begin
        base      = first_desc ? '0 : best_q;
        take      = (fields.clk_raw != '0) && (cand.h_disp > base.h_disp);
        next_best = take ? cand : base;
    end

    // Update the running best per descriptor and latch the record per block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_q  <= '0;
            out_q   <= '0;
            valid_q <= 1'b0;
            dig_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (fields_stb) begin
                best_q <= next_best;
                if (last_desc) begin
                    out_q   <= next_best;
                    valid_q <= (next_best.h_disp >= TIME_W'(MIN_H)) &&
                               (next_best.v_disp >= TIME_W'(MIN_V));
                    dig_q   <= digital_in_i;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign done_o         = done_q;
    assign mode_valid_o   = valid_q;
    assign digital_o      = dig_q;
    assign pclk_o         = out_q.pclk;
    assign h_disp_o       = out_q.h_disp;
    assign h_sync_start_o = out_q.h_ss;
    assign h_sync_end_o   = out_q.h_se;
    assign h_total_o      = out_q.h_tot;
    assign v_disp_o       = out_q.v_disp;
    assign v_sync_start_o = out_q.v_ss;
    assign v_sync_end_o   = out_q.v_se;
    assign v_total_o      = out_q.v_tot;
    assign hsync_pos_o    = out_q.pos_h;
    assign vsync_pos_o    = out_q.pos_v;
    assign interlace_o    = out_q.intl;
endmodule

// File: rtl/edid_native_select_chk.sv
// Property checker for edid_native_select, attached by bind below.
// Observes only the top-level ports.
module edid_native_select_chk
    import edid_sel_pkg::*;
#(
    parameter int MIN_H = 640,
    parameter int MIN_V = 480
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_valid_i,
    input logic              done_o,
    input logic              mode_valid_o,
    input logic [PCLK_W-1:0] pclk_o,
    input logic [TIME_W-1:0] h_disp_o,
    input logic [TIME_W-1:0] h_sync_start_o,
    input logic [TIME_W-1:0] h_sync_end_o,
    input logic [TIME_W-1:0] h_total_o,
    input logic [TIME_W-1:0] v_disp_o,
    input logic [TIME_W-1:0] v_total_o,
    input logic              hsync_pos_o,
    input logic              vsync_pos_o,
    input logic              interlace_o
);
    // R10: done lasts a single cycle
    a_r10_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: done only follows an accepted byte
    a_r10_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(byte_valid_i));

    // R10: record outputs move only together with done
    a_r10_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pclk_o) || !$stable(h_total_o) || !$stable(v_total_o) ||
         !$stable(mode_valid_o)) |-> done_o);

    // R9: a valid mode is never below the minimum size
    a_r9_min_size: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid_o |-> (h_disp_o >= TIME_W'(MIN_H) && v_disp_o >= TIME_W'(MIN_V)));

    // R3: positions are ordered after the active width
    a_r3_sync_order: assert property (@(posedge clk) disable iff (!rst_n)
        (h_disp_o != '0) |-> (h_sync_start_o >= h_disp_o &&
                              h_sync_end_o >= h_sync_start_o &&
                              h_total_o >= h_disp_o));

    // R5: a chosen mode always has a nonzero clock
    a_r5_clock_present: assert property (@(posedge clk) disable iff (!rst_n)
        (h_disp_o != '0) |-> (pclk_o != '0));

    // R7: flags appear only with a chosen mode
    a_r7_flags_need_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_pos_o || vsync_pos_o || interlace_o) |-> (h_disp_o != '0));
endmodule

bind edid_native_select edid_native_select_chk #(
    .MIN_H (MIN_H),
    .MIN_V (MIN_V)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .byte_valid_i   (byte_valid_i),
    .done_o         (done_o),
    .mode_valid_o   (mode_valid_o),
    .pclk_o         (pclk_o),
    .h_disp_o       (h_disp_o),
    .h_sync_start_o (h_sync_start_o),
    .h_sync_end_o   (h_sync_end_o),
    .h_total_o      (h_total_o),
    .v_disp_o       (v_disp_o),
    .v_total_o      (v_total_o),
    .hsync_pos_o    (hsync_pos_o),
    .vsync_pos_o    (vsync_pos_o),
    .interlace_o    (interlace_o)
);

// File: tb/test_edid_native_select.sv
// Scoreboard bench: the driver pushes the expected record for each block,
// and the monitor compares it when done pulses.
module test_edid_native_select;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        byte_valid;
    logic [7:0]  byte_d;
    logic        dig_in;
    logic        done_o, mode_valid_o, hsync_pos_o, vsync_pos_o, interlace_o, digital_o;
    logic [19:0] pclk_o;
    logic [13:0] h_disp_o, h_sync_start_o, h_sync_end_o, h_total_o;
    logic [13:0] v_disp_o, v_sync_start_o, v_sync_end_o, v_total_o;

    always #10 clk = ~clk;

    edid_native_select i_edid_native_select (
        .clk(clk), .rst_n(rst_n), .byte_valid_i(byte_valid), .byte_i(byte_d),
        .digital_in_i(dig_in), .done_o(done_o), .mode_valid_o(mode_valid_o),
        .pclk_o(pclk_o), .h_disp_o(h_disp_o), .h_sync_start_o(h_sync_start_o),
        .h_sync_end_o(h_sync_end_o), .h_total_o(h_total_o), .v_disp_o(v_disp_o),
        .v_sync_start_o(v_sync_start_o), .v_sync_end_o(v_sync_end_o),
        .v_total_o(v_total_o), .hsync_pos_o(hsync_pos_o), .vsync_pos_o(vsync_pos_o),
        .interlace_o(interlace_o), .digital_o(digital_o)
    );

    typedef struct {
        int pclk, ha, hb, va, vb, hso, hsw, vso, vsw, st;
        bit hp, vp, il;
    } dtd_t;
    typedef dtd_t blk_t [4];
    typedef struct {
        int pclk, hd, hss, hse, ht, vd, vss, vse, vt;
        bit hp, vp, il, dig, valid;
    } exp_t;

    exp_t  exp_q[$];
    string ctx_q[$];
    exp_t  last_exp;
    int    vectors = 0, miscompares = 0, dones = 0, blocks = 0;
    bit    done_prev = 1'b0;

    task automatic chk(string req, string ctx, string nm, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d", req, ctx, nm, act, exp);
        end
    endtask

    function automatic dtd_t mk(int pclk, int ha, int hb, int va, int vb, int hso,
                                int hsw, int vso, int vsw, int st, bit hp, bit vp, bit il);
        dtd_t d;
        d.pclk = pclk; d.ha = ha; d.hb = hb; d.va = va; d.vb = vb;
        d.hso = hso; d.hsw = hsw; d.vso = vso; d.vsw = vsw; d.st = st;
        d.hp = hp; d.vp = vp; d.il = il;
        return d;
    endfunction

    // Non-timing descriptor: zero clock, junk elsewhere
    function automatic dtd_t nt();
        return mk(0, 4000, 100, 3000, 50, 20, 20, 3, 3, 3, 1'b1, 1'b1, 1'b1);
    endfunction

    // Byte encoding per R2, R7 and R8
    function automatic logic [7:0] enc(dtd_t d, int i);
        logic [15:0] p;
        logic [11:0] ha, hb, va, vb;
        logic [9:0]  hso, hsw;
        logic [5:0]  vso, vsw;
        logic [1:0]  st;
        p = d.pclk[15:0]; ha = d.ha[11:0]; hb = d.hb[11:0]; va = d.va[11:0];
        vb = d.vb[11:0]; hso = d.hso[9:0]; hsw = d.hsw[9:0];
        vso = d.vso[5:0]; vsw = d.vsw[5:0]; st = d.st[1:0];
        case (i)
            0:  return p[7:0];
            1:  return p[15:8];
            2:  return ha[7:0];
            3:  return hb[7:0];
            4:  return {ha[11:8], hb[11:8]};
            5:  return va[7:0];
            6:  return vb[7:0];
            7:  return {va[11:8], vb[11:8]};
            8:  return hso[7:0];
            9:  return hsw[7:0];
            10: return {vso[3:0], vsw[3:0]};
            11: return {hso[9:8], hsw[9:8], vso[5:4], vsw[5:4]};
            17: return {d.il, 2'b00, st, d.vp, d.hp, 1'b0};
            default: return 8'h5A ^ 8'(i);
        endcase
    endfunction

    // Expected record from the requirements
    function automatic exp_t model(blk_t b, bit dig);
        exp_t e;
        int   bi = -1;
        int   bw = 0;
        e = '{default: 0};
        for (int i = 0; i < 4; i++)
            if (b[i].pclk != 0 && b[i].ha > bw) begin bw = b[i].ha; bi = i; end
        if (bi >= 0) begin
            e.pclk = b[bi].pclk * 10;
            e.hd = b[bi].ha; e.hss = b[bi].ha + b[bi].hso; e.hse = e.hss + b[bi].hsw;
            e.ht = b[bi].ha + b[bi].hb;
            e.vd = b[bi].va; e.vss = b[bi].va + b[bi].vso; e.vse = e.vss + b[bi].vsw;
            e.vt = b[bi].va + b[bi].vb;
            e.hp = (b[bi].st == 3) && b[bi].hp;
            e.vp = (b[bi].st == 3) && b[bi].vp;
            e.il = b[bi].il;
            e.valid = (b[bi].ha >= 640) && (b[bi].va >= 480);
        end
        e.dig = dig;
        return e;
    endfunction

    task automatic cmp_all(exp_t e, string ctx);
        chk("R4",  ctx, "pclk",       int'(pclk_o),         e.pclk);
        chk("R3",  ctx, "h_disp",     int'(h_disp_o),       e.hd);
        chk("R3",  ctx, "h_ss",       int'(h_sync_start_o), e.hss);
        chk("R3",  ctx, "h_se",       int'(h_sync_end_o),   e.hse);
        chk("R3",  ctx, "h_total",    int'(h_total_o),      e.ht);
        chk("R3",  ctx, "v_disp",     int'(v_disp_o),       e.vd);
        chk("R3",  ctx, "v_ss",       int'(v_sync_start_o), e.vss);
        chk("R3",  ctx, "v_se",       int'(v_sync_end_o),   e.vse);
        chk("R3",  ctx, "v_total",    int'(v_total_o),      e.vt);
        chk("R7",  ctx, "hsync_pos",  int'(hsync_pos_o),    int'(e.hp));
        chk("R7",  ctx, "vsync_pos",  int'(vsync_pos_o),    int'(e.vp));
        chk("R8",  ctx, "interlace",  int'(interlace_o),    int'(e.il));
        chk("R11", ctx, "digital",    int'(digital_o),      int'(e.dig));
        chk("R9",  ctx, "mode_valid", int'(mode_valid_o),   int'(e.valid));
    endtask

    // Driver: push expectation, stream 72 bytes, optionally with idle gaps (R13)
    task automatic send_block(blk_t b, bit dig, bit gaps, string ctx);
        exp_q.push_back(model(b, dig));
        ctx_q.push_back(ctx);
        blocks++;
        dig_in = dig;
        for (int d = 0; d < 4; d++) begin
            for (int i = 0; i < 18; i++) begin
                if (gaps && (i % 5 == 2)) begin
                    @(negedge clk);
                    byte_valid = 1'b0;
                    byte_d = 8'hFF;
                end
                @(negedge clk);
                byte_valid = 1'b1;
                byte_d = enc(b[d], i);
            end
        end
        @(negedge clk);
        byte_valid = 1'b0;
        byte_d = 8'h00;
        chk("R10", ctx, "done one cycle after last byte", int'(done_o), 1);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compare against the scoreboard on each done pulse
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (done_o) begin
                if (done_prev)
                    chk("R10", "monitor", "done width", 2, 1);
                if (exp_q.size() == 0) begin
                    chk("R10", "monitor", "unexpected done", 1, 0);
                end else begin
                    last_exp = exp_q.pop_front();
                    cmp_all(last_exp, ctx_q.pop_front());
                    dones++;
                end
            end
            done_prev = done_o;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        blk_t b;
        rst_n = 1'b0; byte_valid = 1'b0; byte_d = 8'h00; dig_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset", "done",       int'(done_o),       0);
        chk("R1", "reset", "mode_valid", int'(mode_valid_o), 0);
        chk("R1", "reset", "pclk",       int'(pclk_o),       0);
        chk("R1", "reset", "h_total",    int'(h_total_o),    0);
        chk("R1", "reset", "v_sync_end", int'(v_sync_end_o), 0);
        chk("R1", "reset", "flags", int'({hsync_pos_o, vsync_pos_o, interlace_o, digital_o}), 0);

        // R2: plain decode of a single timing in slot 0
        b[0] = mk(14850, 1920, 280, 1080, 45, 88, 44, 4, 5, 3, 1'b1, 1'b0, 1'b0);
        b[1] = nt(); b[2] = nt(); b[3] = nt();
        send_block(b, 1'b1, 1'b0, "R2 single");

        // R6: later wider wins; R7: non-separate kind clears polarity
        b[0] = mk(10800, 1280, 408, 1024, 42, 48, 112, 1, 3, 3, 1'b1, 1'b1, 1'b0);
        b[1] = mk(15400, 1920, 160, 1200, 35, 48, 32, 3, 6, 2, 1'b1, 1'b1, 1'b0);
        b[2] = nt(); b[3] = nt();
        send_block(b, 1'b0, 1'b0, "R6 wider later, R7 kind 2");

        // R6: tie keeps first, taller-but-narrower ignored
        b[0] = mk(14625, 1680, 560, 1050, 39, 104, 176, 3, 6, 3, 1'b0, 1'b1, 1'b0);
        b[1] = mk(11900, 1680, 160, 900, 26, 48, 32, 3, 5, 3, 1'b1, 1'b0, 1'b0);
        b[2] = mk(9000, 1024, 300, 1600, 40, 20, 30, 2, 4, 3, 1'b1, 1'b1, 1'b0);
        b[3] = nt();
        send_block(b, 1'b1, 1'b0, "R6 tie");

        // R5: wide zero-clock descriptor skipped
        b[0] = mk(4000, 800, 256, 600, 28, 40, 128, 1, 4, 3, 1'b1, 1'b1, 1'b0);
        b[1] = mk(0, 2560, 160, 1600, 46, 48, 32, 3, 6, 3, 1'b1, 1'b1, 1'b1);
        b[2] = nt(); b[3] = nt();
        send_block(b, 1'b0, 1'b0, "R5 zero clock");

        // R9/R12: no timing at all after earlier blocks
        b[0] = nt(); b[1] = nt(); b[2] = nt(); b[3] = nt();
        send_block(b, 1'b1, 1'b0, "R9 R12 none");

        // R9 boundaries
        b[0] = mk(2518, 640, 160, 480, 45, 16, 96, 10, 2, 0, 1'b1, 1'b1, 1'b0);
        b[1] = nt(); b[2] = nt(); b[3] = nt();
        send_block(b, 1'b0, 1'b0, "R9 640x480");
        b[0] = mk(2518, 639, 160, 480, 45, 16, 96, 10, 2, 3, 1'b0, 1'b0, 1'b0);
        send_block(b, 1'b0, 1'b0, "R9 639 wide");
        b[0] = mk(2518, 640, 160, 479, 45, 16, 96, 10, 2, 3, 1'b0, 1'b0, 1'b0);
        send_block(b, 1'b0, 1'b0, "R9 479 high");

        // R8: interlaced choice in last slot
        b[0] = nt(); b[1] = nt(); b[2] = nt();
        b[3] = mk(7425, 1920, 280, 540, 22, 88, 44, 2, 5, 3, 1'b1, 1'b1, 1'b1);
        send_block(b, 1'b1, 1'b0, "R8 interlace");

        // R3/R4: every field at its maximum
        b[0] = mk(65535, 4095, 4095, 4095, 4095, 1023, 1023, 63, 63, 3, 1'b1, 1'b1, 1'b0);
        b[1] = nt(); b[2] = nt(); b[3] = nt();
        send_block(b, 1'b0, 1'b0, "R3 R4 max fields");

        // R13 with R12: gaps, smaller mode than the previous block
        b[0] = mk(6500, 1024, 320, 768, 38, 24, 136, 3, 6, 1, 1'b1, 1'b1, 1'b0);
        b[1] = mk(5400, 1000, 200, 800, 30, 20, 40, 2, 3, 3, 1'b1, 1'b0, 1'b0);
        b[2] = nt(); b[3] = nt();
        send_block(b, 1'b1, 1'b1, "R13 gaps R12");

        // R10: outputs hold after the pulse while inputs idle
        dig_in = 1'b0;
        repeat (6) @(negedge clk);
        cmp_all(last_exp, "R10 hold");
        chk("R10", "end", "done count", dones, blocks);
        chk("R10", "end", "pending expectations", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule